// File: doc/BRIEF.md
# SDRAM Read/Write Burst Sequencer

This block is the column-command engine of a single-data-rate synchronous DRAM model. A load-mode command programs burst length, burst ordering, read latency and the write-burst policy. Read and write commands then carry a starting column. For every beat of the burst the block emits the column address together with a strobe: write beats appear straight after the command, and read beats are held back by the programmed latency.

A burst ends when its length is used up. It also ends early when a burst-stop or any other command arrives. In full-row mode the burst has no natural end and keeps stepping through the row until another command cuts it off. Row opening, precharge, refresh, bank timing and the storage array are handled elsewhere.

All inputs are sampled on the rising clock edge. The column field is the low `COL_W` bits of `cmd_addr`. The mode word is the low ten bits of `cmd_addr`.

Top module: `sdram_burst_seq`

## Requirements
- R1: Burst length comes from mode bits [2:0]. 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full row. Every other code is illegal.
- R2: In full-row mode, beats continue without limit. The column steps by one each beat and wraps from 255 to 0 (256 columns per row).
- R3: Mode bit [3] = 0 selects sequential order. Beat k's column is `(start & ~m) | ((start + k) & m)`, where m is the burst length minus one, so the address wraps inside the aligned block.
- R4: Mode bit [3] = 1 selects interleaved order. Beat k's column is `start ^ k`.
- R5: Mode bits [6:4] hold the read latency, and only 010 (2) and 011 (3) are legal. If a command is sampled in cycle n, write beat k is strobed in cycle n+1+k and read beat k in cycle n+CL+k.
- R6: With mode bit [9] = 0, writes burst like reads. With bit [9] = 1, each write is a single beat, while reads keep the programmed length.
- R7: Command codes on `cmd_op` are 00 load mode, 01 read, 10 write and 11 burst stop. Any command sampled during a burst ends that burst. Read beats already generated before the stop still emerge after their latency.
- R8: A load-mode word with bits [8:7] not 00, an illegal latency, an illegal length code, or full row combined with interleaved order raises `mode_err` from the next cycle. The previous mode settings stay in force. A legal load clears `mode_err`.
- R9: After reset all strobes and `mode_err` are low. The mode is 1-beat, sequential, latency 2, with burst writes.
- R10: When a write interrupts a read, the read's pending beats and the new write beats can be strobed in the same cycle, each with its own column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Command code (00 load, 01 read, 10 write, 11 stop) |
| cmd_addr | input | ADDR_W | Start column (low COL_W bits) or mode word |
| wr_valid | output | 1 | Write beat strobe |
| wr_col | output | COL_W | Column of the current write beat |
| rd_valid | output | 1 | Read data beat strobe, delayed by the latency |
| rd_col | output | COL_W | Column of the current read beat |
| mode_err | output | 1 | Last load-mode word was rejected |

## Verification
Two functions can fall in the same cycle: the delayed drain of a read and the start of a write that cut it short. The bench provokes this by issuing a read at latency 3 and then, one cycle later, a write. In the cycle that carries the read's only generated beat it expects both strobes high with distinct columns, and in the cycle after it expects the read strobe low while the write continues. A second overlap it judges is a burst-stop landing just as a read burst begins: the one beat already generated must still appear at its latency, and nothing after it.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_STOP  = 2'b11
  } sbs_op_e;

  localparam int MODE_BITS = 10;

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] word,
  output logic [COL_W-1:0]  beat_mask,
  output logic              full_row,
  output logic              interleave,
  output logic              cl3,
  output logic              wr_single,
  output logic              err
);

  logic [2:0]       bl_code;
  logic [2:0]       cl_code;
  logic             legal;
  logic [COL_W-1:0] dec_mask;

  assign bl_code = word[2:0];
  assign cl_code = word[6:4];

  always_comb begin
    legal    = 1'b1;
    dec_mask = '0;
    case (bl_code)
      3'd0:    dec_mask = '0;
      3'd1:    dec_mask = COL_W'(1);
      3'd2:    dec_mask = COL_W'(3);
      3'd3:    dec_mask = COL_W'(7);
      3'd7:    dec_mask = '1;
      default: legal = 1'b0;
    endcase
    if (word[8:7] != 2'b00)                legal = 1'b0;
    if (cl_code != 3'd2 && cl_code != 3'd3) legal = 1'b0;
    if (bl_code == 3'd7 && word[3])         legal = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_mask  <= '0;
      full_row   <= 1'b0;
      interleave <= 1'b0;
      cl3        <= 1'b0;
      wr_single  <= 1'b0;
      err        <= 1'b0;
    end else if (load) begin
      err <= !legal;
      if (legal) begin
        beat_mask  <= dec_mask;
        full_row   <= (bl_code == 3'd7);
        interleave <= word[3];
        cl3        <= (cl_code == 3'd3);
        wr_single  <= word[9];
      end
    end
  end

endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
  import sbs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [COL_W-1:0] beat_mask,
  input  logic             full_row,
  input  logic             interleave,
  input  logic             cl3,
  input  logic             wr_single,
  output logic             gen_rd_v,
  output logic             gen_wr_v,
  output logic [COL_W-1:0] gen_col,
  output logic             gen_cl3
);

  logic             active;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] mask;
  logic             b_il;
  logic             b_full;
  logic             b_rd;
  logic             b_cl3;
  logic [COL_W-1:0] nxt_col;
  logic             is_access;
  logic             single_wr;
  logic [COL_W-1:0] eff_mask;
  logic             eff_full;

  assign is_access = (cmd_op == OP_READ) || (cmd_op == OP_WRITE);
  assign single_wr = (cmd_op == OP_WRITE) && wr_single;
  assign eff_mask  = single_wr ? '0 : beat_mask;
  assign eff_full  = single_wr ? 1'b0 : full_row;

  always_comb begin
    if (b_il) nxt_col = base ^ (cnt & mask);
    else      nxt_col = (base & ~mask) | ((base + cnt) & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      base     <= '0;
      cnt      <= '0;
      mask     <= '0;
      b_il     <= 1'b0;
      b_full   <= 1'b0;
      b_rd     <= 1'b0;
      b_cl3    <= 1'b0;
      gen_rd_v <= 1'b0;
      gen_wr_v <= 1'b0;
      gen_col  <= '0;
      gen_cl3  <= 1'b0;
    end else if (cmd_valid) begin
      if (is_access) begin
        base     <= cmd_col;
        cnt      <= COL_W'(1);
        mask     <= eff_mask;
        b_il     <= interleave;
        b_full   <= eff_full;
        b_rd     <= (cmd_op == OP_READ);
        b_cl3    <= cl3;
        active   <= eff_full || (eff_mask != '0);
        gen_rd_v <= (cmd_op == OP_READ);
        gen_wr_v <= (cmd_op == OP_WRITE);
        gen_col  <= cmd_col;
        gen_cl3  <= cl3;
      end else begin
        active   <= 1'b0;
        gen_rd_v <= 1'b0;
        gen_wr_v <= 1'b0;
      end
    end else if (active) begin
      gen_col  <= nxt_col;
      gen_rd_v <= b_rd;
      gen_wr_v <= !b_rd;
      gen_cl3  <= b_cl3;
      cnt      <= cnt + COL_W'(1);
      active   <= b_full || (cnt != mask);
    end else begin
      gen_rd_v <= 1'b0;
      gen_wr_v <= 1'b0;
    end
  end

endmodule

// File: rtl/sbs_lat_pipe.sv
module sbs_lat_pipe #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic [COL_W-1:0] in_col,
  input  logic             in_cl3,
  output logic             out_v,
  output logic [COL_W-1:0] out_col
);

  logic             hold_v;
  logic [COL_W-1:0] hold_col;
  logic             hold_cl3;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v   <= 1'b0;
      hold_col <= '0;
      hold_cl3 <= 1'b0;
      out_v    <= 1'b0;
      out_col  <= '0;
    end else begin
      hold_v   <= in_v;
      hold_col <= in_col;
      hold_cl3 <= in_cl3;
      if (hold_v && hold_cl3) begin
        out_v   <= 1'b1;
        out_col <= hold_col;
      end else if (in_v && !in_cl3) begin
        out_v   <= 1'b1;
        out_col <= in_col;
      end else begin
        out_v   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_valid,
  output logic [COL_W-1:0]  wr_col,
  output logic              rd_valid,
  output logic [COL_W-1:0]  rd_col,
  output logic              mode_err
);

  localparam int MODE_W = (ADDR_W > MODE_BITS) ? ADDR_W : MODE_BITS;

  logic [COL_W-1:0]  m_mask;
  logic              m_full;
  logic              m_il;
  logic              m_cl3;
  logic              m_wr_single;
  logic              g_rd_v;
  logic              g_wr_v;
  logic [COL_W-1:0]  g_col;
  logic              g_cl3;
  logic              load_cmd;
  logic [MODE_W-1:0] mode_word;

  assign load_cmd  = cmd_valid && (cmd_op == OP_LOAD);
  assign mode_word = MODE_W'(cmd_addr);

  sbs_mode_reg #(.COL_W(COL_W), .ADDR_W(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .load(load_cmd), .word(mode_word),
    .beat_mask(m_mask), .full_row(m_full), .interleave(m_il),
    .cl3(m_cl3), .wr_single(m_wr_single), .err(mode_err)
  );

  sbs_addr_gen #(.COL_W(COL_W)) u_gen (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_col(cmd_addr[COL_W-1:0]), .beat_mask(m_mask), .full_row(m_full),
    .interleave(m_il), .cl3(m_cl3), .wr_single(m_wr_single),
    .gen_rd_v(g_rd_v), .gen_wr_v(g_wr_v), .gen_col(g_col), .gen_cl3(g_cl3)
  );

  sbs_lat_pipe #(.COL_W(COL_W)) u_lat (
    .clk(clk), .rst(rst), .in_v(g_rd_v), .in_col(g_col), .in_cl3(g_cl3),
    .out_v(rd_valid), .out_col(rd_col)
  );

  assign wr_valid = g_wr_v;
  assign wr_col   = g_col;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       wr_valid,
  input logic       rd_valid,
  input logic       mode_err,
  input logic       wsingle
);

  // R8: the error flag only rises after a load-mode command
  assert_err_after_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_err) |-> $past(cmd_valid && cmd_op == 2'b00));

  // R5: a write strobe starts one cycle after a write command
  assert_wr_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> $past(cmd_valid && cmd_op == 2'b10));

  // R5: a read strobe starts two or three cycles after a read command
  assert_rd_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> ($past(cmd_valid && cmd_op == 2'b01, 2) ||
                         $past(cmd_valid && cmd_op == 2'b01, 3)));

  // R7: a burst stop ends any write burst
  assert_stop_ends_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'b11) |=> !wr_valid);

  // R6: in single-write mode consecutive write beats need a fresh write command
  assert_single_wr_R6: assert property (@(posedge clk) disable iff (rst)
    (wsingle && $past(wsingle) && wr_valid && $past(wr_valid))
      |-> $past(cmd_valid && cmd_op == 2'b10));

endmodule

bind sdram_burst_seq sbs_checker i_sbs_checker (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .wr_valid(wr_valid), .rd_valid(rd_valid), .mode_err(mode_err),
  .wsingle(m_wr_single)
);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [9:0] cmd_addr = '0;
  logic       wr_valid, rd_valid, mode_err;
  logic [7:0] wr_col, rd_col;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sdram_burst_seq i_sdram_burst_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_col(wr_col),
    .rd_valid(rd_valid), .rd_col(rd_col), .mode_err(mode_err)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mw(int bl, bit il, int cl, bit ws, int rsv);
    return {ws, 2'(rsv), 3'(cl), il, 3'(bl)};
  endfunction

  function automatic logic [7:0] mcol(logic [7:0] b, int k, int len, bit il);
    logic [7:0] m;
    m = 8'(len - 1);
    if (il) return b ^ (8'(k) & m);
    return (b & ~m) | ((b + 8'(k)) & m);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // drive one command for one cycle; returns at cycle n+1
  task automatic put(logic [1:0] op, logic [9:0] a);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic load_mode(logic [9:0] w, int exp_err, string req);
    put(2'b00, w);
    check(req, int'(mode_err), exp_err);
  endtask

  task automatic test_read(int cl, int blc, bit il, logic [7:0] col, int len, string req);
    load_mode(mw(blc, il, cl, 1'b0, 0), 0, req);
    put(2'b01, {2'b00, col});
    check({req, " idle n+1"}, int'(rd_valid), 0);
    repeat (cl - 1) tick();
    for (int j = 0; j < len; j++) begin
      check({req, " rd_valid"}, int'(rd_valid), 1);
      check({req, " rd_col"}, int'(rd_col), int'(mcol(col, j, len, il)));
      tick();
    end
    check({req, " end"}, int'(rd_valid), 0);
    repeat (3) tick();
  endtask

  task automatic test_reset();
    check("R9 wr_valid", int'(wr_valid), 0);
    check("R9 rd_valid", int'(rd_valid), 0);
    check("R9 mode_err", int'(mode_err), 0);
    put(2'b01, 10'h033);
    tick();
    check("R9 default read beat", int'(rd_valid), 1);
    check("R9 default col", int'(rd_col), 8'h33);
    tick();
    check("R9 default single beat", int'(rd_valid), 0);
    repeat (2) tick();
  endtask

  task automatic test_lengths();
    test_read(2, 0, 1'b0, 8'h21, 1, "R1 BL1");
    test_read(2, 1, 1'b0, 8'h21, 2, "R1 BL2");
    test_read(2, 2, 1'b0, 8'h0E, 4, "R3 BL4 seq wrap");
    test_read(3, 3, 1'b0, 8'h45, 8, "R5 CL3 BL8 seq");
    test_read(3, 3, 1'b1, 8'h35, 8, "R4 BL8 interleaved");
    test_read(2, 2, 1'b1, 8'h12, 4, "R4 BL4 interleaved");
  endtask

  task automatic test_writes();
    load_mode(mw(2, 1'b0, 2, 1'b0, 0), 0, "R6 load burst writes");
    put(2'b10, 10'h009);
    for (int j = 0; j < 4; j++) begin
      check("R6 burst wr_valid", int'(wr_valid), 1);
      check("R6 burst wr_col", int'(wr_col), int'(mcol(8'h09, j, 4, 1'b0)));
      tick();
    end
    check("R6 burst end", int'(wr_valid), 0);
    load_mode(mw(2, 1'b0, 2, 1'b1, 0), 0, "R6 load single writes");
    put(2'b10, 10'h009);
    check("R6 single wr_valid", int'(wr_valid), 1);
    check("R6 single wr_col", int'(wr_col), 8'h09);
    tick();
    check("R6 single end", int'(wr_valid), 0);
    put(2'b01, 10'h009);
    tick();
    for (int j = 0; j < 4; j++) begin
      check("R6 read still bursts", int'(rd_valid), 1);
      tick();
    end
    check("R6 read end", int'(rd_valid), 0);
    repeat (2) tick();
  endtask

  task automatic test_full_row();
    load_mode(mw(7, 1'b0, 2, 1'b0, 0), 0, "R2 load full row");
    put(2'b10, 10'h0FC);
    for (int j = 0; j < 6; j++) begin
      check("R2 full wr_valid", int'(wr_valid), 1);
      check("R2 full wr_col", int'(wr_col), int'(8'(8'hFC + j)));
      if (j == 5) put(2'b11, 10'h000);
      else tick();
    end
    check("R7 stop ends full row", int'(wr_valid), 0);
    repeat (2) tick();
  endtask

  task automatic test_stop_read();
    load_mode(mw(3, 1'b0, 2, 1'b0, 0), 0, "R7 load BL8 CL2");
    put(2'b01, 10'h010);
    put(2'b11, 10'h000);
    check("R7 issued beat emerges", int'(rd_valid), 1);
    check("R7 issued beat col", int'(rd_col), 8'h10);
    tick();
    check("R7 nothing after stop", int'(rd_valid), 0);
    repeat (2) tick();
  endtask

  task automatic test_illegal();
    load_mode(mw(2, 1'b0, 2, 1'b0, 0), 0, "R8 base mode");
    load_mode(mw(2, 1'b0, 1, 1'b0, 0), 1, "R8 bad latency");
    load_mode(mw(4, 1'b0, 2, 1'b0, 0), 1, "R1 bad length code");
    load_mode(mw(2, 1'b0, 3, 1'b0, 1), 1, "R8 reserved bits");
    load_mode(mw(7, 1'b1, 3, 1'b0, 0), 1, "R8 full row interleaved");
    put(2'b01, 10'h006);
    check("R8 err holds", int'(mode_err), 1);
    tick();
    for (int j = 0; j < 4; j++) begin
      check("R8 old mode kept valid", int'(rd_valid), 1);
      check("R8 old mode kept col", int'(rd_col), int'(mcol(8'h06, j, 4, 1'b0)));
      tick();
    end
    check("R8 old mode end", int'(rd_valid), 0);
    load_mode(mw(0, 1'b0, 2, 1'b0, 0), 0, "R8 legal clears err");
    repeat (2) tick();
  endtask

  task automatic test_overlap();
    load_mode(mw(3, 1'b0, 3, 1'b0, 0), 0, "R10 load BL8 CL3");
    put(2'b01, 10'h020);
    put(2'b10, 10'h040);
    check("R10 wr first", int'(wr_valid), 1);
    check("R10 wr first col", int'(wr_col), 8'h40);
    check("R10 rd not yet", int'(rd_valid), 0);
    tick();
    check("R10 both rd", int'(rd_valid), 1);
    check("R10 both rd col", int'(rd_col), 8'h20);
    check("R10 both wr", int'(wr_valid), 1);
    check("R10 both wr col", int'(wr_col), 8'h41);
    tick();
    check("R10 rd cut", int'(rd_valid), 0);
    check("R10 wr goes on", int'(wr_col), 8'h42);
    put(2'b11, 10'h000);
    repeat (2) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    test_reset();
    test_lengths();
    test_writes();
    test_full_row();
    test_stop_read();
    test_illegal();
    test_overlap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule